// File: doc/BRIEF.md
# Receive Frame Admission Counter

This block sits between a receive MAC and the DMA engine that empties a frame-oriented receive FIFO. It keeps a count of the complete frames held in the FIFO, up to a fixed depth of eight. When a new frame starts, it decides whether the frame is stored or thrown away. The storage logic follows that decision for the whole frame, so the FIFO never holds a partial frame. The MAC marks each frame with a start strobe and an end strobe. The DMA side pulses a drain strobe each time it has moved one whole frame out to memory.

When the FIFO is full, the block never applies back-pressure. It discards the newcomer whole and leaves the frames already held untouched; the DMA engine moves them out as it can. Each discarded frame increments a saturating missed-frame counter, which software clears by reading it. Each discard also sets a sticky overflow status bit. Software clears that bit by writing a one to it. The status bit, gated by an enable bit, drives the interrupt line.

Top module: `rx_frame_admit`

## Requirements
- R1: After a synchronous active-low reset, frame_cnt, miss_cnt, ovf_flag, irq, rx_keep and rx_drop are all 0.
- R2: frame_cnt rises by one at the end strobe of a kept frame and falls by one on each drain. It never exceeds DEPTH (8).
- R3: The keep/drop decision appears on rx_keep or rx_drop combinationally in the start-strobe cycle. It stays on the same output up to and including the end-strobe cycle. rx_keep and rx_drop are never high together.
- R4: A frame whose start strobe arrives while frame_cnt is below 8 is kept.
- R5: A frame whose start strobe arrives while frame_cnt is 8, with no drain in that cycle, is dropped. frame_cnt stays 8, including at that frame's end strobe.
- R6: Each dropped frame adds one to miss_cnt in the cycle after its start strobe.
- R7: A drop sets ovf_flag in the next cycle. The flag holds until an ovf_clr pulse, which clears it one cycle later. A drop in the same cycle as ovf_clr leaves the flag set.
- R8: irq equals ovf_flag AND irq_en.
- R9: After a drain takes frame_cnt below 8, the next arriving frame is kept.
- R10: A start strobe at frame_cnt 8 together with a drain is kept, with no miss and no overflow. An end strobe of a kept frame together with a drain leaves frame_cnt unchanged.
- R11: A drain while frame_cnt is 0 leaves it at 0. An end strobe outside any frame changes nothing.
- R12: A miss_rd pulse sets miss_cnt to 0 in the next cycle. If a drop happens in that same cycle, miss_cnt becomes 1 instead.
- R13: miss_cnt saturates at 65535 and stays there on further drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_sof | input | 1 | Frame start strobe from the MAC |
| rx_eof | input | 1 | Frame end strobe from the MAC (may coincide with rx_sof) |
| dma_drain | input | 1 | One whole frame has been moved out to memory |
| miss_rd | input | 1 | Software read of miss_cnt; clears it |
| ovf_clr | input | 1 | Write-one-to-clear strobe for ovf_flag |
| irq_en | input | 1 | Interrupt enable for ovf_flag |
| rx_keep | output | 1 | The current frame is being stored |
| rx_drop | output | 1 | The current frame is being discarded |
| frame_cnt | output | 4 | Number of complete frames held |
| miss_cnt | output | 16 | Count of discarded frames |
| ovf_flag | output | 1 | Sticky overflow status |
| irq | output | 1 | Overflow interrupt |

## Verification
The admission decision is tried in several situations:
- Frames of mixed length, including single-cycle frames where start and end coincide, arrive while the FIFO fills. These show that the count moves only at end strobes and that the decision is held across the frame.
- A frame arrives at exactly eight held frames, with and without a simultaneous drain. This separates a true overflow from the same-cycle drain rescue.
- A drain coincides with an end strobe, and drains and stray end strobes arrive with nothing held. These expose off-by-one and underflow faults.
- A run of tens of thousands of discards shows that the missed-frame counter saturates rather than wraps. Read-clear and write-one-to-clear are each exercised alone and against a simultaneous drop.

// File: rtl/rxa_pkg.sv
// Shared definitions for the receive frame admission counter.
// Assumes nothing beyond standard SystemVerilog packages.
package rxa_pkg;
    localparam int unsigned RXA_DEPTH_DFLT  = 8;
    localparam int unsigned RXA_MISS_W_DFLT = 16;

    // Update applied to the held-frame count in one cycle.
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_UP   = 2'd1,
        CNT_DOWN = 2'd2
    } cnt_op_e;
endpackage

// File: rtl/rxa_occupancy.sv
// Held-frame occupancy and the per-frame admission decision.
// The decision is taken in the start-strobe cycle and held until the
// end strobe. A drain in the start cycle frees a slot for that frame.
// Assumes an end strobe only comes in a start cycle or inside a frame;
// a stray end strobe outside a frame is ignored.
module rxa_occupancy
    import rxa_pkg::*;
#(
    parameter int unsigned DEPTH = RXA_DEPTH_DFLT,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             eof,
    input  logic             drain,
    output logic             keep,
    output logic             drop,
    output logic             drop_evt,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic             in_frm_q;
    logic             keep_q;
    logic [CNT_W-1:0] cnt_q;
    logic             room;
    logic             inc;
    logic             dec;
    cnt_op_e          op;

    // Room exists below the limit, or when a drain frees a slot this cycle.
    assign room = (cnt_q < FULL) || drain;

    // Decision outputs: live in the start cycle, held afterwards.
    always_comb begin
        if (sof) begin
            keep = room;
            drop = !room;
        end else begin
            keep = in_frm_q && keep_q;
            drop = in_frm_q && !keep_q;
        end
    end

    assign drop_evt = sof && !room;
    assign inc      = eof && keep;
    assign dec      = drain && (cnt_q != '0);

    // Select the count update for this cycle.
    always_comb begin
        if (inc && !dec)      op = CNT_UP;
        else if (dec && !inc) op = CNT_DOWN;
        else                  op = CNT_HOLD;
    end

    // Track whether a frame is open and which way it was decided.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frm_q <= 1'b0;
            keep_q   <= 1'b0;
        end else begin
            if (sof) keep_q <= room;
            if (sof && !eof)  in_frm_q <= 1'b1;
            else if (eof)     in_frm_q <= 1'b0;
        end
    end

    // Held-frame count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case (op)
                CNT_UP:   cnt_q <= cnt_q + 1'b1;
                CNT_DOWN: cnt_q <= cnt_q - 1'b1;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt = cnt_q;

    // R2
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

    // R3
    keep_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({keep, drop}));

    // R5
    drop_eof_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eof && drop && !drain) |=> (cnt_q == $past(cnt_q)));

    // R11
    idle_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && drain && !eof) |=> (cnt_q == '0));
endmodule

// File: rtl/rxa_miss_ctr.sv
// Saturating missed-frame counter, cleared by a software read.
// A drop in the same cycle as the read is kept: the counter becomes 1.
module rxa_miss_ctr
    import rxa_pkg::*;
#(
    parameter int unsigned MISS_W = RXA_MISS_W_DFLT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drop_evt,
    input  logic              rd,
    output logic [MISS_W-1:0] miss
);
    localparam logic [MISS_W-1:0] MAXV = {MISS_W{1'b1}};

    logic [MISS_W-1:0] miss_q;

    // Count drops, clear on read, stop at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_q <= '0;
        end else if (rd) begin
            miss_q <= drop_evt ? MISS_W'(1) : '0;
        end else if (drop_evt && (miss_q != MAXV)) begin
            miss_q <= miss_q + 1'b1;
        end
    end

    assign miss = miss_q;

    // R6
    miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_evt && !rd && miss_q != MAXV) |=> (miss_q == $past(miss_q) + 1'b1));

    // R13
    miss_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_q == MAXV && !rd) |=> (miss_q == MAXV));

    // R12
    miss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !drop_evt) |=> (miss_q == '0));
endmodule

// File: rtl/rxa_ovf_status.sv
// Sticky overflow status with write-one-to-clear and an interrupt mask.
// Setting wins over a simultaneous clear so no overflow goes unseen.
module rxa_ovf_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic flag,
    output logic irq
);
    logic flag_q;

    // Hold the status until software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= set || (flag_q && !clr);
    end

    assign flag = flag_q;
    assign irq  = flag_q && en;

    // R7
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag_q);

    // R7
    ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag_q);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/rx_frame_admit.sv
// Receive frame admission counter: admits whole frames into a receive
// FIFO of DEPTH frames, drops the overflow, and reports it through a
// missed-frame counter and a masked sticky status bit.
// Assumes start/end strobes come from one MAC in order, and that each
// drain pulse means one whole frame has left the FIFO.
module rx_frame_admit
    import rxa_pkg::*;
#(
    parameter int unsigned DEPTH  = RXA_DEPTH_DFLT,
    parameter int unsigned MISS_W = RXA_MISS_W_DFLT,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              dma_drain,
    input  logic              miss_rd,
    input  logic              ovf_clr,
    input  logic              irq_en,
    output logic              rx_keep,
    output logic              rx_drop,
    output logic [CNT_W-1:0]  frame_cnt,
    output logic [MISS_W-1:0] miss_cnt,
    output logic              ovf_flag,
    output logic              irq
);
    logic drop_evt;

    rxa_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof      (rx_sof),
        .eof      (rx_eof),
        .drain    (dma_drain),
        .keep     (rx_keep),
        .drop     (rx_drop),
        .drop_evt (drop_evt),
        .cnt      (frame_cnt)
    );

    rxa_miss_ctr #(.MISS_W(MISS_W)) u_miss (
        .clk      (clk),
        .rst_n    (rst_n),
        .drop_evt (drop_evt),
        .rd       (miss_rd),
        .miss     (miss_cnt)
    );

    rxa_ovf_status u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (drop_evt),
        .clr   (ovf_clr),
        .en    (irq_en),
        .flag  (ovf_flag),
        .irq   (irq)
    );

    // R10
    rescue_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sof && dma_drain && !ovf_clr && !ovf_flag) |=> !ovf_flag);

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (ovf_flag && irq_en));
endmodule

// File: tb/tb_rx_frame_admit.sv
// Directed bench for rx_frame_admit: one task per scenario.
module tb_rx_frame_admit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_sof = 1'b0, rx_eof = 1'b0, dma_drain = 1'b0;
    logic        miss_rd = 1'b0, ovf_clr = 1'b0, irq_en = 1'b0;
    logic        rx_keep, rx_drop, ovf_flag, irq;
    logic [3:0]  frame_cnt;
    logic [15:0] miss_cnt;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    rx_frame_admit dut (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .dma_drain(dma_drain), .miss_rd(miss_rd), .ovf_clr(ovf_clr),
        .irq_en(irq_en), .rx_keep(rx_keep), .rx_drop(rx_drop),
        .frame_cnt(frame_cnt), .miss_cnt(miss_cnt), .ovf_flag(ovf_flag),
        .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance to just after the next rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Send one frame of len cycles and check the held decision each cycle.
    task automatic send_frame(input int len, input bit exp_keep);
        for (int i = 0; i < len; i++) begin
            rx_sof = (i == 0);
            rx_eof = (i == len - 1);
            #2;
            chk(rx_keep == exp_keep, "R3 keep", int'(rx_keep), int'(exp_keep));
            chk(rx_drop == !exp_keep, "R3 drop", int'(rx_drop), int'(!exp_keep));
            tick();
        end
        rx_sof = 1'b0;
        rx_eof = 1'b0;
    endtask

    task automatic drain_n(input int n);
        dma_drain = 1'b1;
        repeat (n) tick();
        dma_drain = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(frame_cnt == 0, "R1 cnt", frame_cnt, 0);
        chk(miss_cnt == 0, "R1 miss", miss_cnt, 0);
        chk(!ovf_flag && !irq, "R1 flag", int'(ovf_flag), 0);
        chk(!rx_keep && !rx_drop, "R1 decision", int'(rx_keep | rx_drop), 0);
    endtask

    task automatic t_fill();
        int lens [8] = '{1, 3, 2, 5, 1, 4, 2, 6};
        foreach (lens[k]) begin
            send_frame(lens[k], 1'b1);
            chk(frame_cnt == 4'(k + 1), "R2 R4 fill", frame_cnt, k + 1);
        end
    endtask

    task automatic t_overflow();
        send_frame(3, 1'b0);
        chk(frame_cnt == 8, "R5 cnt", frame_cnt, 8);
        chk(miss_cnt == 1, "R6 miss", miss_cnt, 1);
        chk(ovf_flag, "R7 set", int'(ovf_flag), 1);
        chk(!irq, "R8 masked", int'(irq), 0);
        send_frame(1, 1'b0);
        chk(miss_cnt == 2, "R6 second", miss_cnt, 2);
    endtask

    task automatic t_irq_clear();
        irq_en = 1'b1;
        #1;
        chk(irq, "R8 enabled", int'(irq), 1);
        ovf_clr = 1'b1;
        tick();
        ovf_clr = 1'b0;
        chk(!ovf_flag && !irq, "R7 clear", int'(ovf_flag), 0);
        ovf_clr = 1'b1;
        send_frame(1, 1'b0);
        ovf_clr = 1'b0;
        chk(ovf_flag, "R7 set beats clear", int'(ovf_flag), 1);
        ovf_clr = 1'b1;
        tick();
        ovf_clr = 1'b0;
        chk(!ovf_flag, "R7 clear again", int'(ovf_flag), 0);
    endtask

    task automatic t_readmit();
        drain_n(1);
        chk(frame_cnt == 7, "R9 drain", frame_cnt, 7);
        send_frame(2, 1'b1);
        chk(frame_cnt == 8, "R9 readmit", frame_cnt, 8);
    endtask

    task automatic t_same_cycle();
        rx_sof = 1'b1;
        dma_drain = 1'b1;
        #2;
        chk(rx_keep && !rx_drop, "R10 rescue keep", int'(rx_keep), 1);
        tick();
        rx_sof = 1'b0;
        chk(frame_cnt == 7, "R10 rescue cnt", frame_cnt, 7);
        rx_eof = 1'b1;
        tick();
        rx_eof = 1'b0;
        dma_drain = 1'b0;
        chk(frame_cnt == 7, "R10 eof+drain", frame_cnt, 7);
        chk(!ovf_flag, "R10 no ovf", int'(ovf_flag), 0);
        chk(miss_cnt == 3, "R10 no miss", miss_cnt, 3);
    endtask

    task automatic t_ignored();
        drain_n(7);
        chk(frame_cnt == 0, "R2 empty", frame_cnt, 0);
        drain_n(2);
        chk(frame_cnt == 0, "R11 drain at 0", frame_cnt, 0);
        rx_eof = 1'b1;
        tick();
        rx_eof = 1'b0;
        chk(frame_cnt == 0, "R11 stray eof", frame_cnt, 0);
    endtask

    task automatic t_miss_read();
        miss_rd = 1'b1;
        tick();
        miss_rd = 1'b0;
        chk(miss_cnt == 0, "R12 read clear", miss_cnt, 0);
        repeat (8) send_frame(1, 1'b1);
        miss_rd = 1'b1;
        send_frame(1, 1'b0);
        miss_rd = 1'b0;
        chk(miss_cnt == 1, "R12 read with drop", miss_cnt, 1);
    endtask

    task automatic t_saturate();
        rx_sof = 1'b1;
        rx_eof = 1'b1;
        repeat (65540) tick();
        rx_sof = 1'b0;
        rx_eof = 1'b0;
        chk(miss_cnt == 16'hFFFF, "R13 saturate", miss_cnt, 65535);
        chk(frame_cnt == 8, "R5 full after run", frame_cnt, 8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        t_overflow();
        t_irq_clear();
        t_readmit();
        t_same_cycle();
        t_ignored();
        t_miss_read();
        t_saturate();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule